// File: doc/BRIEF.md
# Dual Event Compare Timer Bank

This block holds a row of identical 32-bit timers behind one small register port. Each timer has a free-running up-counter, a compare register and a control register. While its run bit is set, the counter steps up by one every clock cycle and rolls over from all ones back to zero. Software can load the counter and the compare value at any time, and can read every register back.

Each timer produces two interrupt events on its own pair of lines. The even line pulses when the counter steps past the compare value, meaning it moves from equal to the compare value to one above it. The odd line pulses when the counter rolls over to zero. The compare event fires once per programming: it is armed again only by a write to the counter or to the compare register. Both pulses last one cycle, and each is gated by its own interrupt enable. Timer i drives lines 2i and 2i+1, so several timers sit side by side on one interrupt vector. The bus adapter that produces the write strobe, address and data is outside this block, and so is the interrupt controller that consumes the lines.

Top module: `evt_timer_bank`

## Requirements
- R1: After reset every control, counter and compare register reads 0, the compare event of every timer is armed, and every interrupt line is 0.
- R2: The address is {timer index, select}, with the select in the low two bits. Select 0 is control: bit 0 is run, bit 1 is compare interrupt enable, bit 2 is zero interrupt enable, and all other bits read 0. Select 1 is the counter, select 2 is the compare value, and select 3 reads 0 and ignores writes. Reads are combinational from the address.
- R3: While run is 1, the counter increments by one on every clock edge that carries no counter write. While run is 0, the counter holds its value.
- R4: A counter write loads the written value at that clock edge, in place of that cycle's increment.
- R5: The counter wraps from all ones to zero. When zero interrupt enable is set, the timer's odd line (2i+1) pulses in the cycle in which the counter first reads 0.
- R6: An increment from a counter value equal to the compare value is the compare event. When compare interrupt enable is set, the even line (2i) pulses in the cycle in which the counter first reads compare+1 (modulo 2^WIDTH).
- R7: A compare event disarms the timer, and it stays disarmed until the counter or the compare register is written. It disarms the timer even when compare interrupt enable is 0, and a later rise of the enable raises no event.
- R8: Each interrupt pulse lasts one cycle. The enables are sampled on the same edge as the event. Loading the counter with zero or with compare+1 by a write raises no event.
- R9: Timers are independent: writes, counting and events of one timer leave the registers and lines of every other timer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per asserted cycle |
| addr | input | ADDR_W | {timer index, 2-bit register select} |
| wr_data | input | WIDTH | Write data |
| rd_data | output | WIDTH | Combinational read data for addr |
| irq_o | output | 2*N_TIMERS | Event pulses: line 2i compare event, line 2i+1 zero event of timer i |

## Verification
On every cycle the assertions check the following. After reset the lines and counters are clear. A stopped counter holds its value and a running one steps by exactly one. A compare pulse only appears with the counter at compare+1, and a zero pulse only with the counter at zero. Neither pulse lasts more than one cycle, and neither appears unless its enable was set on the edge before it. The bench scenarios show what needs a history: the event fires once per programming, it is re-armed by a write, and an arm spent while the enable was off stays spent. They also show that a counter write overrides the increment, that the register map reads back correctly, and that the timers stay independent, using long runs through full wraps of a narrow counter.

// File: rtl/evt_timer_pkg.sv
// Package: shared types of the dual event timer bank.
// Assumes the register select occupies the two lowest address bits.
package evt_timer_pkg;

    // Register select carried in addr[1:0]
    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_COUNT = 2'd1,
        SEL_CMP   = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    // Control register layout, bit 0 = run, bit 1 = compare irq enable, bit 2 = zero irq enable
    typedef struct packed {
        logic zero_ie;
        logic cmp_ie;
        logic run;
    } ctrl_t;

    localparam int CTRL_W = 3;

endpackage

// File: rtl/evt_timer_decode.sv
// Module: evt_timer_decode
// Turns the bus write strobe and address into one write strobe per register
// per timer. Assumes the address is {timer index, 2-bit select}; an index
// beyond the timer count or select 3 produces no strobe.
module evt_timer_decode
    import evt_timer_pkg::*;
#(
    parameter int N_TIMERS = 2,
    parameter int ADDR_W   = 3
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [N_TIMERS-1:0] ctrl_wr,
    output logic [N_TIMERS-1:0] cnt_wr,
    output logic [N_TIMERS-1:0] cmp_wr
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    reg_sel_e         sel;

    // Split the address into timer index and register select
    always_comb begin
        idx = addr[ADDR_W-1:2];
        sel = reg_sel_e'(addr[1:0]);
    end

    genvar gi;
    generate
        for (gi = 0; gi < N_TIMERS; gi++) begin : g_dec
            logic hit;
            // Timer gi is addressed by a write
            always_comb hit = wr_en && (idx == IDX_W'(gi));

            // Per-register strobes of timer gi
            always_comb begin
                ctrl_wr[gi] = hit && (sel == SEL_CTRL);
                cnt_wr[gi]  = hit && (sel == SEL_COUNT);
                cmp_wr[gi]  = hit && (sel == SEL_CMP);
            end
        end
    endgenerate

endmodule

// File: rtl/evt_timer_core.sv
// Module: evt_timer_core
// Registers and counter of one timer: control, counter and compare value.
// The counter steps once per cycle while run is set; a counter write
// replaces that step. It reports each step and each rewrite to the event
// logic. Assumes WIDTH >= CTRL_W so control data fits in the write word.
module evt_timer_core
    import evt_timer_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             ctrl_wr,
    input  logic             cnt_wr,
    input  logic             cmp_wr,
    output ctrl_t            ctrl_q,
    output logic [WIDTH-1:0] cnt_q,
    output logic [WIDTH-1:0] cmp_q,
    output logic             step,
    output logic             rearm
);

    // A counter step happens when running and not overridden by a write
    always_comb begin
        step  = ctrl_q.run && !cnt_wr;
        rearm = cnt_wr || cmp_wr;
    end

    // Control register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    // Counter: write load takes priority over the increment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_wr) begin
            cnt_q <= wr_data;
        end else if (step) begin
            cnt_q <= cnt_q + WIDTH'(1);
        end
    end

    // Compare register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else if (cmp_wr) begin
            cmp_q <= wr_data;
        end
    end

endmodule

// File: rtl/evt_timer_events.sv
// Module: evt_timer_events
// Event detection of one timer. The compare event is an increment leaving
// the compare value while armed; it disarms until the next rewrite. The
// zero event is an increment leaving all ones. Both outputs are registered
// one-cycle pulses, gated by the enables seen on the event's edge, so they
// line up with the counter value that follows the event.
module evt_timer_events #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] cnt_q,
    input  logic [WIDTH-1:0] cmp_q,
    input  logic             step,
    input  logic             rearm,
    input  logic             cmp_ie,
    input  logic             zero_ie,
    output logic             irq_cmp,
    output logic             irq_zero
);

    localparam logic [WIDTH-1:0] CNT_MAX = '1;

    logic armed;
    logic cmp_hit;
    logic zero_hit;

    // Raw events of this cycle; a rewrite suppresses the compare event
    always_comb begin
        cmp_hit  = step && armed && !rearm && (cnt_q == cmp_q);
        zero_hit = step && (cnt_q == CNT_MAX);
    end

    // Arm flag: set by a rewrite, spent by a compare event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b1;
        end else if (rearm) begin
            armed <= 1'b1;
        end else if (cmp_hit) begin
            armed <= 1'b0;
        end
    end

    // Registered, enable-gated event pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_cmp  <= 1'b0;
            irq_zero <= 1'b0;
        end else begin
            irq_cmp  <= cmp_hit && cmp_ie;
            irq_zero <= zero_hit && zero_ie;
        end
    end

endmodule

// File: rtl/evt_timer_rdmux.sv
// Module: evt_timer_rdmux
// Combinational read path. Selects one register of one timer by address;
// control is zero-extended, select 3 and unused indices read zero.
module evt_timer_rdmux
    import evt_timer_pkg::*;
#(
    parameter int N_TIMERS = 2,
    parameter int WIDTH    = 32,
    parameter int ADDR_W   = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  ctrl_t             ctrl_arr [N_TIMERS],
    input  logic [WIDTH-1:0]  cnt_arr  [N_TIMERS],
    input  logic [WIDTH-1:0]  cmp_arr  [N_TIMERS],
    output logic [WIDTH-1:0]  rd_data
);

    localparam int IDX_W = ADDR_W - 2;

    // Pick the addressed timer and register
    always_comb begin
        rd_data = '0;
        for (int t = 0; t < N_TIMERS; t++) begin
            if (addr[ADDR_W-1:2] == IDX_W'(t)) begin
                case (reg_sel_e'(addr[1:0]))
                    SEL_CTRL:  rd_data = WIDTH'(ctrl_arr[t]);
                    SEL_COUNT: rd_data = cnt_arr[t];
                    SEL_CMP:   rd_data = cmp_arr[t];
                    default:   rd_data = '0;
                endcase
            end
        end
    end

endmodule

// File: rtl/evt_timer_bank.sv
// Module: evt_timer_bank (top)
// A row of N_TIMERS dual event timers behind one register port. Timer i
// drives irq_o[2i] with its compare event and irq_o[2i+1] with its zero
// event. Assumes one write per cycle and WIDTH >= 3.
module evt_timer_bank
    import evt_timer_pkg::*;
#(
    parameter  int N_TIMERS = 2,
    parameter  int WIDTH    = 32,
    localparam int IDX_W    = (N_TIMERS > 1) ? $clog2(N_TIMERS) : 1,
    localparam int ADDR_W   = IDX_W + 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [WIDTH-1:0]      wr_data,
    output logic [WIDTH-1:0]      rd_data,
    output logic [2*N_TIMERS-1:0] irq_o
);

    logic [N_TIMERS-1:0] ctrl_wr;
    logic [N_TIMERS-1:0] cnt_wr;
    logic [N_TIMERS-1:0] cmp_wr;
    ctrl_t               ctrl_arr [N_TIMERS];
    logic [WIDTH-1:0]    cnt_arr  [N_TIMERS];
    logic [WIDTH-1:0]    cmp_arr  [N_TIMERS];

    evt_timer_decode #(
        .N_TIMERS (N_TIMERS),
        .ADDR_W   (ADDR_W)
    ) u_decode (
        .wr_en   (wr_en),
        .addr    (addr),
        .ctrl_wr (ctrl_wr),
        .cnt_wr  (cnt_wr),
        .cmp_wr  (cmp_wr)
    );

    genvar gi;
    generate
        for (gi = 0; gi < N_TIMERS; gi++) begin : g_tmr
            logic step;
            logic rearm;

            evt_timer_core #(
                .WIDTH (WIDTH)
            ) u_core (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_data (wr_data),
                .ctrl_wr (ctrl_wr[gi]),
                .cnt_wr  (cnt_wr[gi]),
                .cmp_wr  (cmp_wr[gi]),
                .ctrl_q  (ctrl_arr[gi]),
                .cnt_q   (cnt_arr[gi]),
                .cmp_q   (cmp_arr[gi]),
                .step    (step),
                .rearm   (rearm)
            );

            evt_timer_events #(
                .WIDTH (WIDTH)
            ) u_events (
                .clk      (clk),
                .rst_n    (rst_n),
                .cnt_q    (cnt_arr[gi]),
                .cmp_q    (cmp_arr[gi]),
                .step     (step),
                .rearm    (rearm),
                .cmp_ie   (ctrl_arr[gi].cmp_ie),
                .zero_ie  (ctrl_arr[gi].zero_ie),
                .irq_cmp  (irq_o[2*gi]),
                .irq_zero (irq_o[2*gi+1])
            );
        end
    endgenerate

    evt_timer_rdmux #(
        .N_TIMERS (N_TIMERS),
        .WIDTH    (WIDTH),
        .ADDR_W   (ADDR_W)
    ) u_rdmux (
        .addr     (addr),
        .ctrl_arr (ctrl_arr),
        .cnt_arr  (cnt_arr),
        .cmp_arr  (cmp_arr),
        .rd_data  (rd_data)
    );

endmodule

// File: rtl/evt_timer_bank_chk.sv
// Module: evt_timer_bank_chk
// Cycle-by-cycle properties of the timer bank, bound to the top module.
// Assumes the address layout {timer index, select} with select 1 = counter.
module evt_timer_bank_chk
    import evt_timer_pkg::*;
#(
    parameter int N_TIMERS = 2,
    parameter int WIDTH    = 32,
    parameter int ADDR_W   = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic [ADDR_W-1:0]     addr,
    input logic [2*N_TIMERS-1:0] irq_o,
    input ctrl_t                 ctrl_arr [N_TIMERS],
    input logic [WIDTH-1:0]      cnt_arr  [N_TIMERS],
    input logic [WIDTH-1:0]      cmp_arr  [N_TIMERS]
);

    // R1
    reset_irq_chk: assert property (@(posedge clk) !rst_n |=> irq_o == '0);

    genvar gi;
    generate
        for (gi = 0; gi < N_TIMERS; gi++) begin : g_chk
            localparam logic [ADDR_W-1:0] CNT_ADDR = ADDR_W'(gi * 4 + 1);
            logic cnt_write;
            // Bus write aimed at this timer's counter
            always_comb cnt_write = wr_en && (addr == CNT_ADDR);

            // R1
            reset_cnt_chk: assert property (@(posedge clk)
                !rst_n |=> cnt_arr[gi] == '0);

            // R3
            hold_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!ctrl_arr[gi].run && !cnt_write) |=> $stable(cnt_arr[gi]));

            // R3
            step_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (ctrl_arr[gi].run && !cnt_write) |=>
                cnt_arr[gi] == WIDTH'($past(cnt_arr[gi]) + WIDTH'(1)));

            // R6
            cmp_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
                irq_o[2*gi] |-> cnt_arr[gi] == WIDTH'(cmp_arr[gi] + WIDTH'(1)));

            // R5
            zero_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
                irq_o[2*gi+1] |-> cnt_arr[gi] == '0);

            // R8
            cmp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
                irq_o[2*gi] |=> !irq_o[2*gi]);

            // R8
            zero_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
                irq_o[2*gi+1] |=> !irq_o[2*gi+1]);

            // R8
            cmp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(irq_o[2*gi]) |-> $past(ctrl_arr[gi].cmp_ie));

            // R8
            zero_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(irq_o[2*gi+1]) |-> $past(ctrl_arr[gi].zero_ie));
        end
    endgenerate

endmodule

bind evt_timer_bank evt_timer_bank_chk #(
    .N_TIMERS (N_TIMERS),
    .WIDTH    (WIDTH),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .addr     (addr),
    .irq_o    (irq_o),
    .ctrl_arr (ctrl_arr),
    .cnt_arr  (cnt_arr),
    .cmp_arr  (cmp_arr)
);

// File: tb/evt_timer_bank_bench.sv
// Bench: two 8-bit timers, full-wrap sweeps with arithmetic expectations.
module evt_timer_bank_bench;

    localparam int NT = 2;
    localparam int W  = 8;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [W-1:0]  rd_data;
    logic [2*NT-1:0] irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    evt_timer_bank #(.N_TIMERS(NT), .WIDTH(W)) u_evt_timer_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One register write; returns 1 ns after the edge that takes it
    task automatic wr(int t, int s, int d);
        @(negedge clk);
        wr_en = 1'b1; addr = AW'(t * 4 + s); wr_data = W'(d);
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(int t, int s, output int v);
        addr = AW'(t * 4 + s);
        #1;
        v = int'(rd_data);
    endtask

    // Follow timer t for n edges from counter value start, expecting compare
    // pulses at step ca (or none for -1) and zero pulses when zon is set
    task automatic watch(string req, int t, int start, int n, int ca, bit zon);
        int v;
        for (int j = 1; j <= n; j++) begin
            int ec;
            @(posedge clk);
            #1;
            ec = (start + j) % 256;
            rd(t, 1, v);
            chk({req, " counter"}, v, ec);
            chk({req, " compare line"}, int'(irq_o[2*t]), (j == ca) ? 1 : 0);
            chk({req, " zero line"}, int'(irq_o[2*t+1]), (zon && ec == 0) ? 1 : 0);
            chk("R9 other pair quiet", int'(irq_o[2*(1-t)+:2]), 0);
        end
    endtask

    initial begin
        int v;
        int c0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        // R1 reset state
        for (int t = 0; t < NT; t++) begin
            for (int s = 0; s < 4; s++) begin
                rd(t, s, v);
                chk("R1 register after reset", v, 0);
            end
        end
        chk("R1 lines after reset", int'(irq_o), 0);

        // R2 control bits read back, others zero; select 3 ignored
        wr(1, 0, 8'hFE);
        rd(1, 0, v); chk("R2 control readback", v, 6);
        wr(1, 0, 8'hF8);
        rd(1, 0, v); chk("R2 control upper bits", v, 0);
        wr(0, 3, 8'hFF);
        rd(0, 3, v); chk("R2 select 3 reads 0", v, 0);
        for (int s = 0; s < 3; s++) begin
            rd(0, s, v); chk("R2 select 3 write ignored", v, 0);
        end

        // R3 R4 R6 R7: count from 10, compare 20, one pulse over a full wrap
        wr(0, 1, 10);
        wr(0, 2, 20);
        rd(0, 1, v); chk("R4 counter load", v, 10);
        rd(0, 2, v); chk("R2 compare readback", v, 20);
        wr(0, 0, 3);
        watch("R6 R7 single compare", 0, 10, 300, 11, 1'b0);
        rd(1, 1, v); chk("R9 stopped timer counter", v, 0);

        // R5 R6: wrap with both enables
        wr(0, 0, 0);
        wr(0, 1, 250);
        wr(0, 2, 20);
        wr(0, 0, 7);
        watch("R5 wrap", 0, 250, 300, 27, 1'b1);

        // R7: arm spent while enable is off
        wr(0, 0, 0);
        wr(0, 1, 30);
        wr(0, 2, 33);
        wr(0, 0, 1);
        watch("R7 disabled spend", 0, 30, 10, -1, 1'b0);
        wr(0, 0, 3);
        watch("R7 no late event", 0, 41, 260, -1, 1'b0);

        // R7: compare rewrite re-arms while running (counter at 45 before write)
        wr(0, 2, 50);
        watch("R7 rearm", 0, 46, 10, 5, 1'b0);

        // R4: write overrides increment while running
        wr(0, 1, 100);
        rd(0, 1, v); chk("R4 override", v, 100);
        @(posedge clk); #1;
        rd(0, 1, v); chk("R4 resume", v, 101);

        // R8: loading zero raises no zero event
        wr(0, 0, 7);
        wr(0, 1, 0);
        rd(0, 1, v); chk("R8 zero load value", v, 0);
        chk("R8 zero load no pulse", int'(irq_o[1]), 0);
        @(posedge clk); #1;
        rd(0, 1, v); chk("R8 count after zero load", v, 1);
        chk("R8 still no pulse", int'(irq_o[1]), 0);

        // R9: timer 1 runs while timer 0 is stopped
        wr(0, 0, 0);
        rd(0, 1, c0);
        wr(1, 2, 2);
        wr(1, 0, 3);
        watch("R9 timer 1", 1, 0, 6, 3, 1'b0);
        rd(0, 1, v); chk("R9 timer 0 held", v, c0);
        rd(0, 2, v); chk("R9 timer 0 compare kept", v, 50);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule